// File: doc/BRIEF.md
# SCSI Initiator Selection Command Sequencer

This block sits between a host register port and an abstract SCSI target port on the initiator side. The host reaches a small register bank through an address latch. Writing the command register starts one of the following:

- a software reset,
- a disconnect,
- a select-only probe,
- a combined select-and-transfer.

The combined command does four things in turn: it asks the addressed target whether it is present, optionally sends an identify message, hands over a twelve-byte command descriptor block, and then waits for the phase the target reports next. From that phase the block sets the SCSI status byte, the auxiliary status byte and its own bus-phase state.

Byte-by-byte data movement belongs to a separate transfer engine. When that engine finishes, it reports completion and a final status byte, and this block then returns the bus to the free state. While a command is in progress, any further command is refused. This busy interlock keeps the host from starting a second selection over an active one.

Top module: `scsi_sel_seq`

## Requirements
- R1: While auxiliary status bit 4 (command in progress) is set, or a selection sequence is still running, a written command changes nothing: status, auxiliary status, target ID and the stored command byte keep their values.
- R2: Command 0x00 clears registers 0x01 to 0x1A and the address latch, clears the transfer counter, and sets SCSI status to 0x01 when bit 3 of register 0x00 is set, else 0x00. Register 0x00 keeps its value.
- R3: Command 0x04 with the bus already free clears the transfer counter, leaves SCSI and auxiliary status unchanged, and sends no disconnect notice to the target.
- R4: Commands 0x06 and 0x07 take the target ID from bits [2:0] of register 0x15, set SCSI status 0x42 and auxiliary status 0x80, clear the transfer counter, and issue no select request.
- R5: Commands 0x08 and 0x09 issue one select request to the target in register 0x15. If the target is absent, or a transfer is already executing, SCSI status becomes 0x42, auxiliary status 0x80 and the transfer counter clears.
- R6: After a successful select, command 0x08 sends one identify message equal to register 0x0F ORed with 0x80, before the command block. Command 0x09 sends none.
- R7: The command block goes out as one strobe. Byte k (bits 8k+7:8k) holds register 0x03+k, for k from 0 to 11.
- R8: The target's next phase is coded 0 = status, 1 = execute, 2 = data-in, 3 = data-out. Their effects are:
  - Status: the target status is copied to register 0x0F, SCSI status becomes 0x16, one disconnect notice is sent, auxiliary status becomes 0x80 and the bus phase becomes free (0).
  - Execute: auxiliary status becomes 0x30 and the bus phase becomes 1.
  - Data: auxiliary status becomes 0x31, one buffer-index clear pulse is sent, and the bus phase becomes 2 or 3.
- R9: Completion from the transfer engine while the bus is not free does the following: it copies the engine status to register 0x0F, sets SCSI status 0x16 and auxiliary status 0x80, sends one disconnect notice and frees the bus.
- R10: Commands 0x02, 0x18 and undefined codes are stored in the command register and have no other effect.
- R11: Each host access moves the address latch up by one, except at 0x18, 0x19 and 0x1F. Registers 0x12, 0x13 and 0x14 hold the high, middle and low bytes of the transfer counter. Register 0x17 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_adr_we | input | 1 | Load the address latch |
| host_adr | input | 5 | Register address for the latch |
| host_wr | input | 1 | Write strobe at the latched address |
| host_rd | input | 1 | Read strobe (advances the latch) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Register at the latched address |
| scsi_stat | output | 8 | SCSI status byte |
| aux_stat | output | 8 | Auxiliary status byte |
| bus_phase | output | 3 | Bus phase: 0 free, 1 execute, 2 data-in, 3 data-out |
| tgt_sel_req | output | 1 | Select request to the target |
| tgt_id | output | 3 | Selected target ID |
| tgt_present | input | 1 | Target answers the select request |
| tgt_msg_vld | output | 1 | Identify message strobe |
| tgt_msg | output | 8 | Identify message byte |
| tgt_cdb_vld | output | 1 | Command block strobe |
| tgt_cdb | output | 96 | Command block, byte k at bits 8k+7:8k |
| tgt_ph_vld | input | 1 | Target next phase valid |
| tgt_ph | input | 2 | Target next phase code |
| tgt_status | input | 8 | Target status byte for the status phase |
| tgt_disc | output | 1 | Disconnect notice to the target |
| buf_clr | output | 1 | Buffer index clear to the transfer engine |
| xfe_done | input | 1 | Transfer engine completion |
| xfe_status | input | 8 | Final status from the transfer engine |

## Verification
Select-and-transfer runs repeatedly with a random target ID, LUN byte, command block, ATN choice, returned phase and target status. About one run in five has the target absent. These runs separate the four phase outcomes from one another and from the timeout path, and they check the identify message against the no-ATN variant.

Directed cases cover the rest:
- refused commands during execute and data phases, which separate the interlock from normal decoding;
- the no-effect command codes;
- select-only;
- disconnect on a free bus;
- software reset with and without the advanced-features bit;
- latch stepping across the counter bytes, the data register and the read-only status register.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

  typedef enum logic [2:0] {
    PH_FREE = 3'd0,
    PH_EXEC = 3'd1,
    PH_DIN  = 3'd2,
    PH_DOUT = 3'd3,
    PH_STAT = 3'd4
  } bus_phase_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SEL,
    SQ_MSG,
    SQ_CDB,
    SQ_WAIT
  } seq_state_e;

  // register addresses the logic decodes
  localparam logic [4:0] A_OWN      = 5'h00;
  localparam logic [4:0] A_CDB0     = 5'h03;
  localparam logic [4:0] A_LUN      = 5'h0F;
  localparam logic [4:0] A_TC_HI    = 5'h12;
  localparam logic [4:0] A_DST      = 5'h15;
  localparam logic [4:0] A_WR_LAST  = 5'h16;
  localparam logic [4:0] A_STAT     = 5'h17;
  localparam logic [4:0] A_CMD      = 5'h18;
  localparam logic [4:0] A_DATA     = 5'h19;
  localparam logic [4:0] A_TOP      = 5'h1A;
  localparam logic [4:0] A_AUX      = 5'h1F;

  // command codes
  localparam logic [7:0] C_RESET    = 8'h00;
  localparam logic [7:0] C_DROP     = 8'h04;
  localparam logic [7:0] C_PROBE_A  = 8'h06;
  localparam logic [7:0] C_PROBE    = 8'h07;
  localparam logic [7:0] C_LAUNCH_A = 8'h08;
  localparam logic [7:0] C_LAUNCH   = 8'h09;

  // status codes
  localparam logic [7:0] ST_RST     = 8'h00;
  localparam logic [7:0] ST_RST_ADV = 8'h01;
  localparam logic [7:0] ST_DONE    = 8'h16;
  localparam logic [7:0] ST_TMO     = 8'h42;
  localparam logic [7:0] ST_DISC    = 8'h85;

  localparam logic [7:0] AX_INT     = 8'h80;
  localparam logic [7:0] AX_BUSY    = 8'h30;
  localparam logic [7:0] AX_READY   = 8'h31;
  localparam int         AX_CIP_BIT = 4;

  // target phase codes
  localparam logic [1:0] TP_STATUS  = 2'd0;
  localparam logic [1:0] TP_EXEC    = 2'd1;
  localparam logic [1:0] TP_DIN     = 2'd2;
  localparam logic [1:0] TP_DOUT    = 2'd3;

endpackage

// File: rtl/scsi_seq_regfile.sv
module scsi_seq_regfile
  import scsi_seq_pkg::*;
#(
  parameter int CDB_N = 12,
  parameter int TC_W  = 24,
  parameter int ID_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adr_we,
  input  logic [4:0]           adr_in,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [7:0]           stat_in,
  input  logic [7:0]           aux_in,
  input  logic                 cmd_blocked,
  output logic                 cmd_stb,
  output logic [7:0]           cmd_code,
  input  logic                 soft_clr,
  input  logic                 tc_clr,
  input  logic                 tlun_we,
  input  logic [7:0]           tlun_val,
  output logic                 own_adv,
  output logic [ID_W-1:0]      dst_id,
  output logic [7:0]           lun,
  output logic [8*CDB_N-1:0]   cdb
);

  localparam int NREG     = int'(A_TOP) + 1;
  localparam int TC_BYTES = TC_W / 8;

  logic [7:0]      regs_q [NREG];
  logic [7:0]      regs_d [NREG];
  logic [4:0]      lat_q, lat_d;
  logic [TC_W-1:0] tc_q, tc_d;
  logic            tc_hit;
  int              tc_sel;

  assign tc_hit   = (lat_q >= A_TC_HI) && (int'(lat_q) < int'(A_TC_HI) + TC_BYTES);
  assign tc_sel   = TC_BYTES - 1 - (int'(lat_q) - int'(A_TC_HI));
  assign cmd_stb  = wr && (lat_q == A_CMD);
  assign cmd_code = wdata;

  // next-state
  always_comb begin
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    lat_d = lat_q;
    tc_d  = tc_q;
    if (adr_we) begin
      lat_d = adr_in;
    end else if (wr || rd) begin
      if (!(lat_q == A_CMD || lat_q == A_DATA || lat_q == A_AUX)) lat_d = lat_q + 5'd1;
    end
    if (wr) begin
      if (lat_q == A_CMD) begin
        if (!cmd_blocked) regs_d[A_CMD] = wdata;
      end else if (lat_q == A_DATA) begin
        regs_d[A_DATA] = wdata;
      end else if (tc_hit) begin
        tc_d[8*tc_sel +: 8] = wdata;
      end else if (lat_q <= A_WR_LAST) begin
        regs_d[lat_q] = wdata;
      end
    end
    if (soft_clr) begin
      for (int i = 1; i < NREG; i++) regs_d[i] = 8'h00;
      lat_d = 5'd0;
    end
    if (tlun_we) regs_d[A_LUN] = tlun_val;
    if (tc_clr)  tc_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
      lat_q <= 5'd0;
      tc_q  <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      lat_q <= lat_d;
      tc_q  <= tc_d;
    end
  end

  // read mux
  always_comb begin
    if (tc_hit)                rdata = tc_q[8*tc_sel +: 8];
    else if (lat_q == A_STAT)  rdata = stat_in;
    else if (lat_q == A_AUX)   rdata = aux_in;
    else if (lat_q <= A_TOP)   rdata = regs_q[lat_q];
    else                       rdata = 8'hFF;
  end

  assign own_adv = regs_q[A_OWN][3];
  assign dst_id  = regs_q[A_DST][ID_W-1:0];
  assign lun     = regs_q[A_LUN];

  for (genvar k = 0; k < CDB_N; k++) begin : g_cdb
    assign cdb[8*k +: 8] = regs_q[int'(A_CDB0) + k];
  end

  AST_LATCH_HOLDS_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) && !adr_we && !soft_clr && lat_q == A_DATA |=> lat_q == A_DATA); // R11
  AST_RESET_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> lat_q == 5'd0 && tc_q == '0); // R2

endmodule

// File: rtl/scsi_seq_ctrl.sv
module scsi_seq_ctrl
  import scsi_seq_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_stb,
  input  logic [7:0]      cmd_code,
  output logic            cmd_blocked,
  output logic            soft_clr,
  output logic            tc_clr,
  output logic            tlun_we,
  output logic [7:0]      tlun_val,
  input  logic            own_adv,
  input  logic [ID_W-1:0] dst_id,
  input  logic [7:0]      lun,
  output logic [7:0]      scsi_stat,
  output logic [7:0]      aux_stat,
  output logic [2:0]      bus_phase,
  output logic            tgt_sel_req,
  output logic [ID_W-1:0] tgt_id,
  input  logic            tgt_present,
  output logic            tgt_msg_vld,
  output logic [7:0]      tgt_msg,
  output logic            tgt_cdb_vld,
  input  logic            tgt_ph_vld,
  input  logic [1:0]      tgt_ph,
  input  logic [7:0]      tgt_status,
  output logic            tgt_disc,
  output logic            buf_clr,
  input  logic            xfe_done,
  input  logic [7:0]      xfe_status
);

  seq_state_e      seq_q, seq_d;
  bus_phase_e      ph_q, ph_d;
  logic [7:0]      stat_q, stat_d, aux_q, aux_d;
  logic [ID_W-1:0] tid_q, tid_d;
  logic            atn_q, atn_d;
  logic            disc_q, disc_d, bclr_q, bclr_d;
  logic            cmd_ok, timeout, drop_req, drop_force;

  assign cmd_blocked = aux_q[AX_CIP_BIT] || (seq_q != SQ_IDLE);
  assign cmd_ok      = cmd_stb && !cmd_blocked;

  // next-state
  always_comb begin
    seq_d = seq_q;  ph_d  = ph_q;  stat_d = stat_q; aux_d = aux_q;
    tid_d = tid_q;  atn_d = atn_q;
    disc_d = 1'b0;  bclr_d = 1'b0;
    tc_clr = 1'b0;  tlun_we = 1'b0; tlun_val = tgt_status; soft_clr = 1'b0;
    timeout = 1'b0; drop_req = 1'b0; drop_force = 1'b0;
    case (seq_q)
      SQ_IDLE: begin
        if (xfe_done && ph_q != PH_FREE) begin
          tlun_we  = 1'b1;
          tlun_val = xfe_status;
          stat_d   = ST_DONE;
          drop_req = 1'b1;
        end else if (cmd_ok) begin
          case (cmd_code)
            C_RESET: begin
              soft_clr = 1'b1;
              drop_req = 1'b1;
            end
            C_DROP: drop_req = 1'b1;
            C_PROBE_A, C_PROBE: begin
              tid_d   = dst_id;
              timeout = 1'b1;
            end
            C_LAUNCH_A, C_LAUNCH: begin
              tid_d = dst_id;
              atn_d = (cmd_code == C_LAUNCH_A);
              if (ph_q == PH_EXEC) timeout = 1'b1;
              else                 seq_d   = SQ_SEL;
            end
            default: ;
          endcase
        end
      end
      SQ_SEL: begin
        if (tgt_present) begin
          seq_d = atn_q ? SQ_MSG : SQ_CDB;
        end else begin
          timeout = 1'b1;
          seq_d   = SQ_IDLE;
        end
      end
      SQ_MSG: seq_d = SQ_CDB;
      SQ_CDB: seq_d = SQ_WAIT;
      SQ_WAIT: begin
        if (tgt_ph_vld) begin
          seq_d = SQ_IDLE;
          case (tgt_ph)
            TP_STATUS: begin
              tlun_we    = 1'b1;
              tlun_val   = tgt_status;
              stat_d     = ST_DONE;
              drop_req   = 1'b1;
              drop_force = 1'b1;
            end
            TP_EXEC: begin
              ph_d  = PH_EXEC;
              aux_d = AX_BUSY;
            end
            TP_DIN: begin
              ph_d   = PH_DIN;
              aux_d  = AX_READY;
              bclr_d = 1'b1;
            end
            default: begin
              ph_d   = PH_DOUT;
              aux_d  = AX_READY;
              bclr_d = 1'b1;
            end
          endcase
        end
      end
      default: seq_d = SQ_IDLE;
    endcase

    if (timeout) begin
      stat_d = ST_TMO;
      aux_d  = AX_INT;
      tc_clr = 1'b1;
    end
    if (drop_req) begin
      tc_clr = 1'b1;
      if (ph_q != PH_FREE || drop_force) begin
        disc_d = 1'b1;
        if (stat_d != ST_DONE) stat_d = ST_DISC;
        aux_d  = AX_INT;
        ph_d   = PH_FREE;
      end
    end
    if (soft_clr) stat_d = own_adv ? ST_RST_ADV : ST_RST;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      ph_q   <= PH_FREE;
      stat_q <= ST_RST;
      aux_q  <= AX_INT;
      tid_q  <= '0;
      atn_q  <= 1'b0;
      disc_q <= 1'b0;
      bclr_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      ph_q   <= ph_d;
      stat_q <= stat_d;
      aux_q  <= aux_d;
      tid_q  <= tid_d;
      atn_q  <= atn_d;
      disc_q <= disc_d;
      bclr_q <= bclr_d;
    end
  end

  assign scsi_stat   = stat_q;
  assign aux_stat    = aux_q;
  assign bus_phase   = ph_q;
  assign tgt_id      = tid_q;
  assign tgt_sel_req = (seq_q == SQ_SEL);
  assign tgt_msg_vld = (seq_q == SQ_MSG);
  assign tgt_msg     = lun | 8'h80;
  assign tgt_cdb_vld = (seq_q == SQ_CDB);
  assign tgt_disc    = disc_q;
  assign buf_clr     = bclr_q;

  AST_REFUSED_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && aux_q[AX_CIP_BIT] && seq_q == SQ_IDLE && !xfe_done
    |=> $stable(scsi_stat) && $stable(aux_stat) && $stable(bus_phase)); // R1
  AST_ABSENT_TIMES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel_req && !tgt_present |=> scsi_stat == ST_TMO && aux_stat == AX_INT); // R5
  AST_IDENT_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_msg_vld |-> tgt_msg[7] && $past(tgt_sel_req)); // R6
  AST_CDB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_cdb_vld |-> $past(tgt_sel_req) || $past(tgt_msg_vld)); // R7
  AST_DISC_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_disc |-> bus_phase == PH_FREE && aux_stat == AX_INT); // R9
  AST_EXEC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_phase == PH_EXEC |-> aux_stat == AX_BUSY); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tgt_sel_req, tgt_msg_vld, tgt_cdb_vld, tgt_disc})); // R6

endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
  import scsi_seq_pkg::*;
#(
  parameter int CDB_N = 12,
  parameter int TC_W  = 24,
  parameter int ID_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_adr_we,
  input  logic [4:0]          host_adr,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  output logic [7:0]          scsi_stat,
  output logic [7:0]          aux_stat,
  output logic [2:0]          bus_phase,
  output logic                tgt_sel_req,
  output logic [ID_W-1:0]     tgt_id,
  input  logic                tgt_present,
  output logic                tgt_msg_vld,
  output logic [7:0]          tgt_msg,
  output logic                tgt_cdb_vld,
  output logic [8*CDB_N-1:0]  tgt_cdb,
  input  logic                tgt_ph_vld,
  input  logic [1:0]          tgt_ph,
  input  logic [7:0]          tgt_status,
  output logic                tgt_disc,
  output logic                buf_clr,
  input  logic                xfe_done,
  input  logic [7:0]          xfe_status
);

  logic            cmd_blocked, cmd_stb, soft_clr, tc_clr, tlun_we, own_adv;
  logic [7:0]      cmd_code, tlun_val, lun;
  logic [ID_W-1:0] dst_id;

  scsi_seq_regfile #(.CDB_N(CDB_N), .TC_W(TC_W), .ID_W(ID_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .adr_we      (host_adr_we),
    .adr_in      (host_adr),
    .wr          (host_wr),
    .rd          (host_rd),
    .wdata       (host_wdata),
    .rdata       (host_rdata),
    .stat_in     (scsi_stat),
    .aux_in      (aux_stat),
    .cmd_blocked (cmd_blocked),
    .cmd_stb     (cmd_stb),
    .cmd_code    (cmd_code),
    .soft_clr    (soft_clr),
    .tc_clr      (tc_clr),
    .tlun_we     (tlun_we),
    .tlun_val    (tlun_val),
    .own_adv     (own_adv),
    .dst_id      (dst_id),
    .lun         (lun),
    .cdb         (tgt_cdb)
  );

  scsi_seq_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_stb     (cmd_stb),
    .cmd_code    (cmd_code),
    .cmd_blocked (cmd_blocked),
    .soft_clr    (soft_clr),
    .tc_clr      (tc_clr),
    .tlun_we     (tlun_we),
    .tlun_val    (tlun_val),
    .own_adv     (own_adv),
    .dst_id      (dst_id),
    .lun         (lun),
    .scsi_stat   (scsi_stat),
    .aux_stat    (aux_stat),
    .bus_phase   (bus_phase),
    .tgt_sel_req (tgt_sel_req),
    .tgt_id      (tgt_id),
    .tgt_present (tgt_present),
    .tgt_msg_vld (tgt_msg_vld),
    .tgt_msg     (tgt_msg),
    .tgt_cdb_vld (tgt_cdb_vld),
    .tgt_ph_vld  (tgt_ph_vld),
    .tgt_ph      (tgt_ph),
    .tgt_status  (tgt_status),
    .tgt_disc    (tgt_disc),
    .buf_clr     (buf_clr),
    .xfe_done    (xfe_done),
    .xfe_status  (xfe_status)
  );

endmodule

// File: tb/tb_scsi_sel_seq.sv
module tb_scsi_sel_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_adr_we = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [4:0]  host_adr = '0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic [7:0]  scsi_stat, aux_stat, tgt_msg;
  logic [2:0]  bus_phase, tgt_id;
  logic        tgt_sel_req, tgt_present, tgt_msg_vld, tgt_cdb_vld, tgt_disc, buf_clr;
  logic [95:0] tgt_cdb;
  logic        tgt_ph_vld = 1'b1;
  logic [1:0]  tgt_ph = '0;
  logic [7:0]  tgt_status = '0;
  logic        xfe_done = 1'b0;
  logic [7:0]  xfe_status = '0;
  logic [7:0]  pres_mask = '0;

  int tests = 0, fails = 0;
  int n_sel = 0, n_msg = 0, n_cdb = 0, n_disc = 0, n_bclr = 0;
  logic [7:0]  msg_cap;
  logic [95:0] cdb_cap;
  logic        msg_first;

  always #10 clk = ~clk;

  assign tgt_present = pres_mask[tgt_id];

  scsi_sel_seq dut (
    .clk(clk), .rst_n(rst_n),
    .host_adr_we(host_adr_we), .host_adr(host_adr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .scsi_stat(scsi_stat), .aux_stat(aux_stat), .bus_phase(bus_phase),
    .tgt_sel_req(tgt_sel_req), .tgt_id(tgt_id), .tgt_present(tgt_present),
    .tgt_msg_vld(tgt_msg_vld), .tgt_msg(tgt_msg), .tgt_cdb_vld(tgt_cdb_vld), .tgt_cdb(tgt_cdb),
    .tgt_ph_vld(tgt_ph_vld), .tgt_ph(tgt_ph), .tgt_status(tgt_status),
    .tgt_disc(tgt_disc), .buf_clr(buf_clr), .xfe_done(xfe_done), .xfe_status(xfe_status)
  );

  always @(negedge clk) begin
    if (tgt_sel_req) n_sel++;
    if (tgt_msg_vld) begin n_msg++; msg_cap = tgt_msg; msg_first = (n_cdb == 0); end
    if (tgt_cdb_vld) begin n_cdb++; cdb_cap = tgt_cdb; end
    if (tgt_disc) n_disc++;
    if (buf_clr) n_bclr++;
  end

  task automatic chk(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_sel = 0; n_msg = 0; n_cdb = 0; n_disc = 0; n_bclr = 0; msg_first = 1'b0;
  endtask

  task automatic hw_addr(input logic [4:0] a);
    host_adr_we = 1'b1; host_adr = a; @(negedge clk); host_adr_we = 1'b0;
  endtask
  task automatic hw_wr(input logic [7:0] v);
    host_wr = 1'b1; host_wdata = v; @(negedge clk); host_wr = 1'b0;
  endtask
  task automatic hw_rd(output logic [7:0] v);
    v = host_rdata; host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
  endtask
  task automatic put_reg(input logic [4:0] a, input logic [7:0] v);
    hw_addr(a); hw_wr(v);
  endtask
  task automatic get_reg(input logic [4:0] a, output logic [7:0] v);
    hw_addr(a); v = host_rdata;
  endtask
  task automatic issue(input logic [7:0] c);
    put_reg(5'h18, c);
  endtask

  function automatic logic [7:0] f_aux(input logic [1:0] ph);
    case (ph)
      2'd0:    return 8'h80;
      2'd1:    return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
  function automatic logic [2:0] f_phase(input logic [1:0] ph);
    return (ph == 2'd0) ? 3'd0 : {1'b0, ph};
  endfunction
  function automatic logic [7:0] f_stat(input logic [1:0] ph, input logic [7:0] prev);
    return (ph == 2'd0) ? 8'h16 : prev;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0]  v, prev_stat, lun, ts, xs, c0, st0, ax0;
    logic [2:0]  id;
    logic [1:0]  ph;
    logic        atn, pres;
    logic [95:0] cdb;
    v = $urandom(32'h5EED_2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R2", "reset aux", aux_stat, 8'h80);
    chk("R2", "reset status", scsi_stat, 8'h00);
    chk("R8", "reset phase", bus_phase, 3'd0);
    chk("R11", "reset rdata at latch 0", host_rdata, 8'h00);

    // R11 latch stepping and counter bytes
    hw_addr(5'h03);
    for (int k = 0; k < 12; k++) hw_wr(8'hA0 + 8'(k));
    hw_addr(5'h03);
    for (int k = 0; k < 12; k++) begin hw_rd(v); chk("R11", "cdb reg readback", v, 8'hA0 + 8'(k)); end
    hw_addr(5'h12); hw_wr(8'h12); hw_wr(8'h34); hw_wr(8'h56);
    hw_addr(5'h12); hw_rd(v); chk("R11", "tc hi", v, 8'h12);
    hw_rd(v); chk("R11", "tc mid", v, 8'h34);
    hw_rd(v); chk("R11", "tc lo", v, 8'h56);
    put_reg(5'h17, 8'h55);
    chk("R11", "status read-only", scsi_stat, 8'h00);
    hw_addr(5'h19); hw_wr(8'h11); hw_wr(8'h22);
    chk("R11", "data reg holds latch", host_rdata, 8'h22);

    // R4 select-only
    put_reg(5'h15, 8'hFD);
    clr_mon();
    issue(8'h07);
    @(negedge clk);
    chk("R4", "status", scsi_stat, 8'h42);
    chk("R4", "aux", aux_stat, 8'h80);
    chk("R4", "target id", tgt_id, 3'd5);
    chk("R4", "no select request", n_sel, 0);
    get_reg(5'h13, v); chk("R4", "tc cleared", v, 8'h00);
    put_reg(5'h15, 8'h02);
    issue(8'h06); @(negedge clk);
    chk("R4", "atn variant id", tgt_id, 3'd2);

    // R3 disconnect on free bus
    put_reg(5'h14, 8'h77);
    clr_mon();
    issue(8'h04); @(negedge clk);
    chk("R3", "status kept", scsi_stat, 8'h42);
    chk("R3", "aux kept", aux_stat, 8'h80);
    chk("R3", "no notice", n_disc, 0);
    get_reg(5'h14, v); chk("R3", "tc cleared", v, 8'h00);

    // R10 no-effect commands
    foreach (c0[i]) ;
    for (int j = 0; j < 3; j++) begin
      c0 = (j == 0) ? 8'h02 : (j == 1) ? 8'h18 : 8'h3F;
      clr_mon();
      issue(c0); @(negedge clk);
      chk("R10", "status unchanged", scsi_stat, 8'h42);
      chk("R10", "aux unchanged", aux_stat, 8'h80);
      chk("R10", "no strobes", n_sel + n_disc, 0);
      get_reg(5'h18, v); chk("R10", "command stored", v, c0);
    end

    // R5 absent target
    pres_mask = 8'h00;
    put_reg(5'h15, 8'h04); put_reg(5'h14, 8'h09);
    clr_mon();
    issue(8'h09); repeat (4) @(negedge clk);
    chk("R5", "one select request", n_sel, 1);
    chk("R5", "no cdb", n_cdb, 0);
    chk("R5", "timeout status", scsi_stat, 8'h42);
    chk("R5", "aux int", aux_stat, 8'h80);
    get_reg(5'h14, v); chk("R5", "tc cleared", v, 8'h00);
    prev_stat = 8'h42;

    // random select-and-transfer, R6 R7 R8 R1 R9
    for (int it = 0; it < 40; it++) begin
      id = 3'($urandom); lun = 8'($urandom); atn = 1'($urandom);
      ph = 2'($urandom); pres = ($urandom % 5) != 0; ts = 8'($urandom);
      for (int k = 0; k < 12; k++) cdb[8*k +: 8] = 8'($urandom);
      put_reg(5'h15, {5'($urandom), id});
      put_reg(5'h0F, lun);
      hw_addr(5'h03);
      for (int k = 0; k < 12; k++) hw_wr(cdb[8*k +: 8]);
      pres_mask = pres ? (8'h01 << id) : ~(8'h01 << id);
      tgt_ph = ph; tgt_status = ts;
      c0 = atn ? 8'h08 : 8'h09;
      clr_mon();
      issue(c0); repeat (8) @(negedge clk);
      chk("R5", "select request count", n_sel, 1);
      if (!pres) begin
        chk("R5", "absent status", scsi_stat, 8'h42);
        chk("R5", "absent aux", aux_stat, 8'h80);
        chk("R5", "absent phase", bus_phase, 3'd0);
        chk("R7", "absent no cdb", n_cdb, 0);
        prev_stat = 8'h42;
      end else begin
        chk("R6", "identify count", n_msg, atn ? 1 : 0);
        if (atn) begin
          chk("R6", "identify value", msg_cap, lun | 8'h80);
          chk("R6", "identify before cdb", msg_first, 1'b1);
        end
        chk("R7", "cdb count", n_cdb, 1);
        chk("R7", "cdb bytes", cdb_cap, cdb);
        chk("R8", "aux", aux_stat, f_aux(ph));
        chk("R8", "phase", bus_phase, f_phase(ph));
        chk("R8", "status", scsi_stat, f_stat(ph, prev_stat));
        chk("R8", "disconnect notices", n_disc, (ph == 2'd0) ? 1 : 0);
        chk("R8", "buffer clear pulses", n_bclr, (ph >= 2'd2) ? 1 : 0);
        if (ph == 2'd0) begin
          get_reg(5'h0F, v); chk("R8", "target status copied", v, ts);
          prev_stat = 8'h16;
        end else begin
          // refused command while busy
          st0 = scsi_stat; ax0 = aux_stat;
          put_reg(5'h15, {5'd0, ~id});
          clr_mon();
          issue(8'h07); @(negedge clk);
          chk("R1", "status kept", scsi_stat, st0);
          chk("R1", "aux kept", aux_stat, ax0);
          chk("R1", "target id kept", tgt_id, id);
          get_reg(5'h18, v); chk("R1", "command byte kept", v, c0);
          // completion from transfer engine
          xs = 8'($urandom);
          xfe_status = xs; xfe_done = 1'b1; @(negedge clk); xfe_done = 1'b0;
          @(negedge clk);
          chk("R9", "status done", scsi_stat, 8'h16);
          chk("R9", "aux int", aux_stat, 8'h80);
          chk("R9", "bus free", bus_phase, 3'd0);
          chk("R9", "one notice", n_disc, 1);
          get_reg(5'h0F, v); chk("R9", "engine status copied", v, xs);
          prev_stat = 8'h16;
        end
      end
    end

    // R2 software reset with and without advanced bit
    put_reg(5'h00, 8'h08);
    put_reg(5'h0F, 8'h5A); put_reg(5'h15, 8'h03); put_reg(5'h13, 8'h44);
    issue(8'h00); @(negedge clk);
    chk("R2", "status advanced", scsi_stat, 8'h01);
    chk("R2", "latch at zero", host_rdata, 8'h08);
    get_reg(5'h0F, v); chk("R2", "lun cleared", v, 8'h00);
    get_reg(5'h15, v); chk("R2", "dst cleared", v, 8'h00);
    get_reg(5'h13, v); chk("R2", "tc cleared", v, 8'h00);
    put_reg(5'h00, 8'h00);
    issue(8'h00); @(negedge clk);
    chk("R2", "status plain", scsi_stat, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule